// File: doc/BRIEF.md
# I2C Byte-Memory Target with Block Select

This block answers on an I2C bus as a byte-addressable memory held in on-chip flops. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It also finds the rising and falling SCL edges that carry each bit. SDA is driven only low, through an output-enable signal, so the pad behaves as open drain.

A transaction begins with an 8-bit address byte whose bit 0 is the R/W flag. The block claims the transaction when the address byte matches a base value under a match mask. In a write, one or two word-offset bytes load an internal pointer, and the bytes after them are stored at that pointer. In a read, stored bytes are shifted out starting at the pointer. The pointer steps after every data byte and wraps at the memory capacity. Selected bits of the address byte can act as a block number that reaches the upper part of the memory.

A random read is a write of the offset, then a repeated START with the read flag set. A STOP returns the pointer to zero.

Top module: `i2c_nvm_target`

## Requirements
- R1: After reset every memory location reads 0xFF and SDA is released (`sda_oe` low).
- R2: An address byte `a` is ACKed exactly when `(a & cfg_mask) == (cfg_base & cfg_mask)` over all 8 bits, with R/W in bit 0 (1 = read). Otherwise the block stays silent until the next START.
- R3: In a claimed write, the block ACKs every byte that follows the address byte.
- R4: When `MEM_BYTES` exceeds 256, the first offset byte sets pointer bits 7:0 and the second sets bits 15:8. Otherwise a single offset byte sets the pointer.
- R5: Once the last offset byte has arrived, the pointer gains 256 × `((a[7:1] & cfg_blk_sel) - (cfg_base[7:1] & cfg_blk_sel))`, taken modulo 128.
- R6: Each write data byte is stored at the pointer, and the pointer then steps by one.
- R7: In a read, the byte at the pointer is sent MSB first and the pointer then steps by one. A controller ACK (SDA low on the ninth clock) requests the next byte.
- R8: The pointer wraps modulo `MEM_BYTES`, which is a power of two.
- R9: A STOP clears the pointer and the byte index and deselects the block.
- R10: A START or repeated START clears the byte index and keeps the pointer, so an offset write followed by a repeated-START read returns data from that offset.
- R11: SDA is released on the ninth clock of every read byte. After a controller NACK, no further data is driven until the next START or STOP.
- R12: A transaction whose address byte does not match changes no memory location and no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_base | input | 8 | Address byte value the block answers to |
| cfg_mask | input | 8 | Bits of the address byte that must equal `cfg_base` |
| cfg_blk_sel | input | 7 | Bits of address byte [7:1] used as a block number |

## Verification
Address matching is swept over all 256 address bytes under two mask settings. One setting ignores the R/W bit and the other accepts only reads across a range of block bits. This shows whether the R/W bit is part of the compare. Data traffic covers a write at a low offset with its read back, and a write through a block-selected address that is read back through the plain address and a high offset byte, which checks the block addition against the two-byte offset. A write that runs over the top of memory checks the wrap. A read after STOP and a random read through a repeated START show which condition clears the pointer. A read that continues after a NACK over a zero byte, and writes sent to a foreign address, show that the block stays silent and leaves memory unchanged.

// File: rtl/i2c_nvm_pkg.sv
package i2c_nvm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // not selected, waiting for START
    ST_ADDR,   // shifting in the address byte
    ST_AACK,   // driving ACK for the address byte
    ST_WRX,    // shifting in an offset or data byte
    ST_WACK,   // driving ACK for a written byte
    ST_RTX,    // shifting out a read byte
    ST_RACK    // controller ACK/NACK clock
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q     = scl_ff[STAGES-1];
  assign sda_q     = sda_ff[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2c_nvm_target.sv
module i2c_nvm_target
  import i2c_nvm_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] cfg_base,
  input  logic [7:0] cfg_mask,
  input  logic [6:0] cfg_blk_sel
);
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int OFS_BYTES = (MEM_BYTES > 256) ? 2 : 1;
  localparam logic [1:0] OFS_LAST = 2'(OFS_BYTES - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic sda_q, scl_rise, scl_fall, start_det, stop_det;
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e    state_q, state_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [7:0]    sh_q, sh_n;
  logic [7:0]    abyte_q, abyte_n;
  logic [1:0]    idx_q, idx_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          oe_q, oe_n;
  logic          cack_q, cack_n;
  logic          mem_we;
  logic [7:0]    rd_data;
  logic [15:0]   ptr_w;
  logic [6:0]    blk;

  nvm_array #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_sn), .we(mem_we), .addr(ptr_q),
    .wdata(sh_q), .rdata(rd_data)
  );

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    abyte_n = abyte_q;
    idx_n   = idx_q;
    ptr_n   = ptr_q;
    oe_n    = oe_q;
    cack_n  = cack_q;
    mem_we  = 1'b0;
    ptr_w   = 16'(ptr_q);
    blk     = (abyte_q[7:1] & cfg_blk_sel) - (cfg_base[7:1] & cfg_blk_sel);
    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      ptr_n   = '0;
      idx_n   = 2'd0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      oe_n    = 1'b0;
      cnt_n   = 4'd0;
      idx_n   = 2'd0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WRX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_q};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (state_q == ST_ADDR) begin
              if (((sh_q ^ cfg_base) & cfg_mask) == 8'h00) begin
                abyte_n = sh_q;
                oe_n    = 1'b1;
                state_n = ST_AACK;
              end else begin
                state_n = ST_IDLE;
              end
            end else begin
              oe_n    = 1'b1;
              state_n = ST_WACK;
              if (idx_q <= OFS_LAST) begin
                if (idx_q == 2'd0) ptr_w = {8'h00, sh_q};
                else               ptr_w = {sh_q, ptr_w[7:0]};
                if (idx_q == OFS_LAST) ptr_w = ptr_w + {1'b0, blk, 8'h00};
                ptr_n = ptr_w[AW-1:0];
              end else begin
                mem_we = 1'b1;
                ptr_n  = ptr_q + 1'b1;
              end
              if (idx_q != 2'd3) idx_n = idx_q + 2'd1;
            end
          end
        end
        ST_AACK, ST_RACK: begin
          if (state_q == ST_RACK && scl_rise) cack_n = ~sda_q;
          if (scl_fall) begin
            cnt_n = 4'd0;
            if ((state_q == ST_AACK && abyte_q[0]) || (state_q == ST_RACK && cack_q)) begin
              sh_n    = rd_data;
              ptr_n   = ptr_q + 1'b1;
              oe_n    = ~rd_data[7];
              state_n = ST_RTX;
            end else if (state_q == ST_AACK) begin
              oe_n    = 1'b0;
              state_n = ST_WRX;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            cnt_n   = 4'd0;
            state_n = ST_WRX;
          end
        end
        ST_RTX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_n    = 1'b0;
              state_n = ST_RACK;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              oe_n  = ~sh_q[6];
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'h00;
      abyte_q <= 8'h00;
      idx_q   <= 2'd0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      cack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      abyte_q <= abyte_n;
      idx_q   <= idx_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      cack_q  <= cack_n;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_nvm_target_chk.sv
module i2c_nvm_target_chk
  import i2c_nvm_pkg::*;
#(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          sda_oe,
  input tgt_state_e    state_q,
  input logic [AW-1:0] ptr_q,
  input logic [1:0]    idx_q,
  input logic          start_det,
  input logic          stop_det,
  input logic          mem_we
);
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_det |=> (ptr_q == '0 && idx_q == 2'd0)); // R9
  AST_START_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_sn)
    start_det |=> (ptr_q == $past(ptr_q) && idx_q == 2'd0)); // R10
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |=> sda_oe); // R3
  AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == ST_IDLE |-> !sda_oe); // R11
  AST_CACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == ST_RACK |-> !sda_oe); // R11
  AST_BUS_COND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_det || stop_det) |-> !mem_we); // R12
endmodule

bind i2c_nvm_target i2c_nvm_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .sda_oe(sda_oe), .state_q(state_q),
  .ptr_q(ptr_q), .idx_q(idx_q), .start_det(start_det),
  .stop_det(stop_det), .mem_we(mem_we)
);

// File: tb/i2c_nvm_target_tb.sv
module i2c_nvm_target_tb;
  localparam int MEM = 512;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [7:0] base = 8'hA0, mask = 8'hFE;
  logic [6:0] bsel = 7'h00;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [MEM];
  logic [7:0] wbuf [4];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_nvm_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cfg_base(base), .cfg_mask(mask), .cfg_blk_sel(bsel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; q(); scl_m = 1'b1; q(); r = sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); d = {d[6:0], r}; end
    bit_io(~ack, r);
  endtask

  function automatic int blk_of(input logic [7:0] a);
    return int'(7'((a[7:1] & bsel) - (base[7:1] & bsel)));
  endfunction

  // write n bytes from wbuf through address byte a at offset {hi,lo}
  task automatic wr_txn(input string req, input logic [7:0] a, input logic [7:0] lo,
                        input logic [7:0] hi, input int n);
    logic ack;
    int loc;
    loc = (int'({hi, lo}) + blk_of(a) * 256) % MEM;
    bus_start();
    wbyte(a & 8'hFE, ack); chk({req, " R2 addr ack"}, ack, 1);
    wbyte(lo, ack);        chk({req, " R3 ofs lo ack"}, ack, 1);
    wbyte(hi, ack);        chk({req, " R4 ofs hi ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], ack); chk({req, " R3 data ack"}, ack, 1);
      ref_mem[(loc + i) % MEM] = wbuf[i];
    end
    bus_stop();
  endtask

  // random read: offset write, repeated START, n bytes, last one NACKed
  task automatic rd_txn(input string req, input logic [7:0] a, input logic [7:0] lo,
                        input logic [7:0] hi, input int n);
    logic ack;
    logic [7:0] d;
    int loc;
    loc = (int'({hi, lo}) + blk_of(a) * 256) % MEM;
    bus_start();
    wbyte(a & 8'hFE, ack); chk({req, " R2 addr ack"}, ack, 1);
    wbyte(lo, ack);        chk({req, " R4 ofs lo ack"}, ack, 1);
    wbyte(hi, ack);        chk({req, " R4 ofs hi ack"}, ack, 1);
    bus_start();
    wbyte(a | 8'h01, ack); chk({req, " R10 read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk({req, " R7 data"}, d, ref_mem[(loc + i) % MEM]);
    end
    bus_stop();
  endtask

  task automatic sweep(input string req);
    logic ack;
    for (int a = 0; a < 256; a++) begin
      bus_start();
      wbyte(8'(a), ack);
      bus_stop();
      chk(req, ack, int'((8'(a) & mask) == (base & mask)));
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < MEM; i++) ref_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 sda released after reset", sda_oe, 0);

    // R2: R/W bit ignored, then reads only over a block range
    base = 8'hA0; mask = 8'hFE; sweep("R2 mask FE");
    base = 8'hA1; mask = 8'hF1; sweep("R2 mask F1");

    base = 8'hA0; mask = 8'hF0; bsel = 7'h01;
    rd_txn("R1 erased", 8'hA0, 8'h23, 8'h01, 3);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn("R6 write", 8'hA0, 8'h10, 8'h00, 3);
    rd_txn("R6 readback", 8'hA0, 8'h0F, 8'h00, 5);

    // R5: address A2 is block 1, lands at 0x105
    wbuf[0] = 8'h5A;
    wr_txn("R5 block write", 8'hA2, 8'h05, 8'h00, 1);
    rd_txn("R5 via high ofs", 8'hA0, 8'h05, 8'h01, 1);
    rd_txn("R5 block 0 untouched", 8'hA0, 8'h05, 8'h00, 1);

    // R8: write across the top of memory
    wbuf[0] = 8'h00; wbuf[1] = 8'h77;
    wr_txn("R8 wrap write", 8'hA0, 8'hFF, 8'h01, 2);
    rd_txn("R8 wrap read", 8'hA0, 8'hFE, 8'h01, 4);
    chk("R8 wrap location 0", ref_mem[0], 8'h77);

    // R9: pointer is zero after STOP
    bus_start();
    wbyte(8'hA1, ack); chk("R9 addr ack", ack, 1);
    rbyte(1'b0, d);    chk("R9 read at 0 after stop", d, 8'h77);
    bus_stop();

    // R11: after NACK over a zero byte, the line stays released
    wbuf[0] = 8'h00;
    wr_txn("R11 setup", 8'hA0, 8'h20, 8'h00, 1);
    rd_txn("R11 nacked read", 8'hA0, 8'h20, 8'h00, 1);
    bus_start();
    wbyte(8'hA0, ack); wbyte(8'h20, ack); wbyte(8'h00, ack);
    bus_start();
    wbyte(8'hA1, ack);
    rbyte(1'b0, d); chk("R11 zero byte", d, 8'h00);
    rbyte(1'b0, d); chk("R11 silent after nack", d, 8'hFF);
    bus_stop();

    // R12: foreign address, offset and data are ignored
    bus_start();
    wbyte(8'h50, ack); chk("R12 no ack", ack, 0);
    wbyte(8'h00, ack); wbyte(8'h00, ack); wbyte(8'hEE, ack);
    chk("R12 no ack on data", ack, 0);
    bus_stop();
    rd_txn("R12 memory unchanged", 8'hA0, 8'h00, 8'h00, 2);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule